// File: doc/BRIEF.md
# Six-Lane Striped Serial Page Memory Controller

This controller builds one wide page memory out of six byte-serial nonvolatile memory devices. The devices run in lockstep: they share one serial clock and one chip select, and each has its own data-out and data-in line. Lane k holds bits [8k+7:8k] of a 48-bit hardware page, and the serial byte address sent to every device is the hardware page number.

Toward the processor the block has one request port. A data read or a store moves a 24-bit word. A virtual address names a word, so each page holds two words: page = virtual address >> 1, and bit 0 picks the half. An instruction fetch reads a whole page and returns its upper 32 bits. After a fetch the controller keeps chip select low with the devices in sequential mode. A fetch of the next page then needs only eight more serial clocks and no command. Any other access first closes that stream.

Top module: `serial_page_mem`

## Requirements
- R1: While reset is high and just after it, spi_cs_n is 1, spi_sck is 0 and ready is 0.
- R2: A data read (kind 0, or kind 3) returns page bits [47:24] (lanes 5..3) when vaddr[0] is 0 and page bits [23:0] (lanes 2..0) when vaddr[0] is 1. Lane k holds page bits [8k+7:8k]. The device byte address is vaddr >> 1.
- R3: Every new transaction drives chip select low. It then sends, MSB first on every lane, the command byte 0x03 (read) and a 24-bit address, followed by eight data clocks. Data is launched while SCK is low and sampled on the SCK rising edge. When the port is idle and closed, a read or fetch raises ready 80 clocks after the accepting edge.
- R4: A fetch (kind 2) returns page bits [47:16] on instr and leaves chip select low afterwards.
- R5: A fetch of page P+1, right after a fetch of page P with no other access between them, raises ready 16 clocks after acceptance. It causes no falling edge on chip select.
- R6: A fetch of any other page while the stream is open takes one clock with chip select high, then a full read transaction: 81 clocks in all.
- R7: A store (kind 1) sends write-enable 0x06 only on the three lanes of the addressed half, and 0x00 on the other three. It then raises chip select for one clock and sends 0x02, the address and one data byte per lane. The other half of the page keeps its contents. Latency is 97 clocks from a closed port and 98 from an open stream.
- R8: A data read or store ends with chip select high. The next fetch is therefore never a streamed one, even when its page is sequential.
- R9: ready is high for exactly one clock per request. No request is accepted during that clock.
- R10: SCK is low whenever chip select is high. One SCK period spans two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request; held until ready |
| kind | input | 2 | 0 read word, 1 store word, 2 fetch instruction, 3 read |
| vaddr | input | VA_W | Virtual word address |
| wdata | input | WORD_W | Store data |
| ready | output | 1 | One-clock completion strobe |
| rdata | output | WORD_W | Read word, valid with ready |
| instr | output | INSTR_W | Fetched instruction, valid with ready |
| spi_sck | output | 1 | Shared serial clock |
| spi_cs_n | output | 1 | Shared chip select, active low |
| spi_mosi | output | LANES | Per-lane data to devices |
| spi_miso | input | LANES | Per-lane data from devices |

## Verification
Each result is due at a fixed count of rising edges after the edge that accepts the request. That count is 16 for a streamed fetch, 80 for a read or fetch from a closed port and 81 from an open one, and 97 or 98 for a store. The bench raises req just after a falling edge and counts rising edges until it sees ready at the next falling edge. It expects the listed count plus the accepting edge, and it samples data, chip select and the follow-up idle clock at those same falling edges. The expected counts and data come from a behavioural model of the page array and the stream state. Behavioural serial devices with a write-enable latch give independent proof that commands and addresses were correct.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_NOP   = 8'h00;

  typedef enum logic [1:0] {FR_STREAM, FR_READ, FR_WREN, FR_WRITE} frame_e;
endpackage

// File: rtl/spm_lane.sv
module spm_lane #(
  parameter int FRAME_W = 40,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  input  logic               miso,
  output logic               mosi,
  output logic [BYTE_W-1:0]  rx_next
);
  logic [FRAME_W-1:0] tx_q;
  logic [BYTE_W-1:0]  rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= frame;
    end else if (shift) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      rx_q <= rx_next;
    end
  end

  assign mosi    = tx_q[FRAME_W-1];
  assign rx_next = {rx_q[BYTE_W-2:0], miso};

  // R3: a frame is never reloaded in the middle of a bit
  a_r3_load_not_in_bit: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int WORD_W  = 24,
  parameter int FRAME_W = 40,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        kind,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              half_in,
  input  logic [WORD_W-1:0] wdata_in,
  output logic              cs_n,
  output logic              sck,
  output logic              load,
  output frame_e            frame_sel,
  output logic              shift,
  output logic              done,
  output logic              ready,
  output logic [PAGE_W-1:0] sel_page,
  output logic              sel_half,
  output logic [WORD_W-1:0] sel_wdata
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_CLOSE, S_XFER, S_GAP} st_e;

  st_e               st_q;
  logic              cs_n_q, sck_q, ph_q, ready_q, wren_q, open_q, half_q;
  logic [CNT_W-1:0]  cnt_q, frame_len;
  logic [1:0]        kind_q, cur_kind;
  logic [PAGE_W-1:0] page_q, next_q;
  logic [WORD_W-1:0] wdata_q;
  logic              accept, hit, cur_write, bit_end, last;

  assign accept    = (st_q == S_IDLE) && req && !ready_q;
  assign cur_kind  = (st_q == S_IDLE) ? kind : kind_q;
  assign cur_write = (cur_kind == KIND_WRITE);
  assign hit       = open_q && (cur_kind == KIND_FETCH) && (page_in == next_q);
  assign bit_end   = (st_q == S_XFER) && ph_q;
  assign last      = bit_end && (cnt_q == CNT_W'(1));

  assign load  = (accept && (hit || cs_n_q)) || (st_q == S_CLOSE) || (st_q == S_GAP);
  assign shift = bit_end;
  assign done  = last && !wren_q;

  always_comb begin
    if (st_q == S_GAP)     frame_sel = FR_WRITE;
    else if (accept && hit) frame_sel = FR_STREAM;
    else if (cur_write)     frame_sel = FR_WREN;
    else                    frame_sel = FR_READ;
    frame_len = (frame_sel == FR_STREAM || frame_sel == FR_WREN) ?
                CNT_W'(BYTE_W) : CNT_W'(FRAME_W);
  end

  assign sel_page  = (st_q == S_IDLE) ? page_in  : page_q;
  assign sel_half  = (st_q == S_IDLE) ? half_in  : half_q;
  assign sel_wdata = (st_q == S_IDLE) ? wdata_in : wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;  cs_n_q <= 1'b1;  sck_q <= 1'b0;  ph_q <= 1'b0;
      cnt_q <= '0;     ready_q <= 1'b0; wren_q <= 1'b0; open_q <= 1'b0;
      next_q <= '0;    kind_q <= KIND_READ; page_q <= '0; half_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      ready_q <= 1'b0;
      if (accept) begin
        kind_q <= kind;  page_q <= page_in;  half_q <= half_in;  wdata_q <= wdata_in;
      end
      unique case (st_q)
        S_IDLE: if (accept) begin
          if (hit) st_q <= S_XFER;
          else if (!cs_n_q) begin
            cs_n_q <= 1'b1;  open_q <= 1'b0;  st_q <= S_CLOSE;
          end else begin
            cs_n_q <= 1'b0;  wren_q <= cur_write;  st_q <= S_XFER;
          end
        end
        S_CLOSE: begin
          cs_n_q <= 1'b0;  wren_q <= cur_write;  st_q <= S_XFER;
        end
        S_GAP: begin
          cs_n_q <= 1'b0;  wren_q <= 1'b0;  st_q <= S_XFER;
        end
        S_XFER: if (!ph_q) begin
          sck_q <= 1'b1;  ph_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;  ph_q <= 1'b0;  cnt_q <= cnt_q - CNT_W'(1);
          if (last) begin
            if (wren_q) begin
              cs_n_q <= 1'b1;  st_q <= S_GAP;
            end else begin
              ready_q <= 1'b1;  st_q <= S_IDLE;
              if (kind_q == KIND_FETCH) begin
                open_q <= 1'b1;  next_q <= page_q + 1'b1;
              end else begin
                cs_n_q <= 1'b1;  open_q <= 1'b0;
              end
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (load) begin
        cnt_q <= frame_len;  ph_q <= 1'b0;
      end
    end
  end

  assign cs_n  = cs_n_q;
  assign sck   = sck_q;
  assign ready = ready_q;

  a_r10_sck_only_selected: assert property (@(posedge clk) disable iff (rst)
    sck_q |-> !cs_n_q);
  a_r9_ready_single: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> !ready_q);
  a_r5_stream_keeps_cs: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (!cs_n_q && st_q == S_XFER));
  a_r8_data_closes: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q != KIND_FETCH) |=> cs_n_q);
  a_r4_fetch_stays_open: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == KIND_FETCH) |=> !cs_n_q);
  a_r3_selected_in_xfer: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_XFER) |-> !cs_n_q);
endmodule

// File: rtl/serial_page_mem.sv
module serial_page_mem
  import spm_pkg::*;
#(
  parameter int LANES   = 6,
  parameter int BYTE_W  = 8,
  parameter int VA_W    = 9,
  parameter int INSTR_W = 32,
  parameter int DEV_AW  = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [1:0]           kind,
  input  logic [VA_W-1:0]      vaddr,
  input  logic [LANES*BYTE_W/2-1:0] wdata,
  output logic                 ready,
  output logic [LANES*BYTE_W/2-1:0] rdata,
  output logic [INSTR_W-1:0]   instr,
  output logic                 spi_sck,
  output logic                 spi_cs_n,
  output logic [LANES-1:0]     spi_mosi,
  input  logic [LANES-1:0]     spi_miso
);
  localparam int PAGE_W     = VA_W - 1;
  localparam int PAGE_BITS  = LANES * BYTE_W;
  localparam int WORD_W     = PAGE_BITS / 2;
  localparam int HALF_LANES = LANES / 2;
  localparam int FRAME_W    = 2 * BYTE_W + DEV_AW;

  logic              load, shift, done, sel_half;
  frame_e            frame_sel;
  logic [PAGE_W-1:0] sel_page;
  logic [WORD_W-1:0] sel_wdata;
  logic [DEV_AW-1:0] dev_addr;
  logic [PAGE_BITS-1:0] page_next;
  logic [WORD_W-1:0]  rdata_q;
  logic [INSTR_W-1:0] instr_q;

  spm_ctrl #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .kind(kind),
    .page_in(vaddr[VA_W-1:1]), .half_in(vaddr[0]), .wdata_in(wdata),
    .cs_n(spi_cs_n), .sck(spi_sck), .load(load), .frame_sel(frame_sel),
    .shift(shift), .done(done), .ready(ready),
    .sel_page(sel_page), .sel_half(sel_half), .sel_wdata(sel_wdata));

  assign dev_addr = DEV_AW'(sel_page);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit UPPER = (g >= HALF_LANES);
    localparam int WB    = g % HALF_LANES;
    logic               mine;
    logic [FRAME_W-1:0] frame;
    logic [BYTE_W-1:0]  rx_next;

    assign mine = sel_half ? !UPPER : UPPER;

    always_comb begin
      unique case (frame_sel)
        FR_STREAM: frame = '0;
        FR_READ:   frame = {BYTE_W'(OP_READ), dev_addr, {BYTE_W{1'b0}}};
        FR_WREN:   frame = {(mine ? BYTE_W'(OP_WREN) : BYTE_W'(OP_NOP)),
                            {(FRAME_W-BYTE_W){1'b0}}};
        default:   frame = {BYTE_W'(OP_WRITE), dev_addr,
                            (mine ? sel_wdata[WB*BYTE_W +: BYTE_W] : {BYTE_W{1'b0}})};
      endcase
    end

    spm_lane #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_lane (
      .clk(clk), .rst(rst), .load(load), .frame(frame), .shift(shift),
      .miso(spi_miso[g]), .mosi(spi_mosi[g]), .rx_next(rx_next));

    assign page_next[g*BYTE_W +: BYTE_W] = rx_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      instr_q <= '0;
    end else if (done) begin
      rdata_q <= sel_half ? page_next[WORD_W-1:0] : page_next[PAGE_BITS-1:WORD_W];
      instr_q <= page_next[PAGE_BITS-1 -: INSTR_W];
    end
  end

  assign rdata = rdata_q;
  assign instr = instr_q;

  // R2: returned data changes only when a transfer completes
  a_r2_data_held: assert property (@(posedge clk) disable iff (rst)
    !$past(done) |-> $stable(rdata_q));
endmodule

// File: tb/sim_serial_page_mem.sv
`timescale 1ns/1ps
module sim_serial_dev #(parameter int LANE = 0) (
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic [7:0]  mem [256];
  logic [7:0]  cmd, sh;
  logic [23:0] adr;
  logic        wel;
  int          bits;

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'((a * 7 + LANE * 31 + 5));
    wel = 0; miso = 0; bits = 0; cmd = 0; sh = 0; adr = 0;
  end

  always @(negedge cs_n) bits = 0;
  always @(posedge cs_n) if (cmd == 8'h02) wel = 0;

  always @(posedge sck) if (cs_n === 1'b0) begin
    bits = bits + 1;
    sh = {sh[6:0], mosi};
    if (bits == 8) begin
      cmd = sh;
      if (cmd == 8'h06) wel = 1;
    end
    if (bits > 8 && bits <= 32) adr = {adr[22:0], mosi};
    if (bits >= 40 && bits % 8 == 0 && cmd == 8'h02 && wel)
      mem[8'((int'(adr) + (bits - 40) / 8))] = sh;
  end

  always @(negedge sck) if (cs_n === 1'b0 && bits >= 32 && cmd == 8'h03)
    miso = mem[8'((int'(adr) + (bits - 32) / 8))][7 - ((bits - 32) % 8)];
endmodule

module sim_serial_page_mem;
  logic        clk = 0, rst = 1, req = 0, ready, sck, cs_n;
  logic [1:0]  kind = 0;
  logic [8:0]  vaddr = 0;
  logic [23:0] wdata = 0, rdata;
  logic [31:0] instr;
  logic [5:0]  mosi, miso;

  always #2.5 clk = ~clk;

  serial_page_mem u0 (
    .clk(clk), .rst(rst), .req(req), .kind(kind), .vaddr(vaddr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .instr(instr), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso));

  for (genvar g = 0; g < 6; g++) begin : g_dev
    sim_serial_dev #(.LANE(g)) u_dev (.cs_n(cs_n), .sck(sck), .mosi(mosi[g]), .miso(miso[g]));
  end

  int checks = 0, errors = 0, cs_falls = 0, mon_bad = 0, m_next = 0;
  bit m_open = 0, finished = 0;
  logic [47:0] ref_pg [256];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge cs_n) cs_falls++;
  always @(negedge clk) if (!rst && cs_n === 1'b1 && sck === 1'b1) mon_bad++;

  task automatic access(int k, int va, logic [23:0] wd, string tag);
    int pg = va >> 1;
    int n = 0, expl, falls0;
    bit hit;
    logic [47:0] p;
    hit = (k == 2) && m_open && (pg == m_next);
    if (k == 2)      expl = hit ? 16 : (m_open ? 81 : 80);
    else if (k == 1) expl = m_open ? 98 : 97;
    else             expl = m_open ? 81 : 80;
    falls0 = cs_falls;
    @(negedge clk);
    req = 1; kind = 2'(k); vaddr = 9'(va); wdata = wd;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!ready && n < 400);
    req = 0;
    chk(n == expl + 1, {tag, " latency"}, 64'(n), 64'(expl + 1));
    p = ref_pg[pg];
    if (k == 0) chk(rdata == (va[0] ? p[23:0] : p[47:24]), {tag, " rdata"},
                    64'(rdata), 64'(va[0] ? p[23:0] : p[47:24]));
    if (k == 2) chk(instr == p[47:16], {tag, " instr"}, 64'(instr), 64'(p[47:16]));
    if (k == 1) begin
      if (va[0]) p[23:0] = wd; else p[47:24] = wd;
      ref_pg[pg] = p;
    end
    if (k == 2) begin m_open = 1; m_next = (pg + 1) % 256; end
    else m_open = 0;
    chk(cs_n == !m_open, {tag, " R8 chip select after access"}, 64'(cs_n), 64'(!m_open));
    if (hit) chk(cs_falls == falls0, "R5 no new command on streamed fetch",
                 64'(cs_falls - falls0), 64'd0);
    @(negedge clk);
    chk(ready == 1'b0, "R9 ready lasts one clock", 64'(ready), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=ready");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 256; p++)
      for (int l = 0; l < 6; l++) ref_pg[p][8*l +: 8] = 8'((p * 7 + l * 31 + 5));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0 && ready == 1'b0, "R1 reset state",
        64'({cs_n, sck, ready}), 64'b100);
    rst = 0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0 && ready == 1'b0, "R1 after reset",
        64'({cs_n, sck, ready}), 64'b100);
    access(0, 10, 0, "R2 R3 read upper word");
    access(0, 11, 0, "R2 read lower word");
    access(3, 13, 0, "R2 kind 3 reads");
    access(2, 20, 0, "R4 cold fetch");
    access(2, 22, 0, "R5 streamed fetch");
    access(2, 25, 0, "R5 streamed fetch odd address");
    access(2, 40, 0, "R6 jump while open");
    access(2, 42, 0, "R5 stream after jump");
    access(0, 7, 0, "R8 read closes stream");
    access(2, 44, 0, "R8 sequential fetch after read is cold");
    access(1, 60, 24'hA1B2C3, "R7 store upper from open");
    access(0, 60, 0, "R7 read back upper");
    access(0, 61, 0, "R7 lower half untouched");
    access(1, 63, 24'h0D0E0F, "R7 store lower cold");
    access(0, 62, 0, "R7 upper half untouched");
    access(0, 63, 0, "R7 read back lower");
    access(2, 60, 0, "R4 fetch stored page");
    access(2, 62, 0, "R5 stream into next page");
    access(1, 64, 24'h123456, "R8 store closes stream");
    access(2, 64, 0, "R8 fetch after store is cold");
    chk(mon_bad == 0, "R10 sck low while deselected", 64'(mon_bad), 64'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule